// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit sits beside the decode stage of a 32-bit RISC pipeline that uses one branch delay slot. Each cycle in which `valid_i` is high it looks at the instruction word, its PC and the two source register values. From these it works out whether control flow changes, the target address, and whether a return address must be written. The instruction that follows a branch or jump always executes. For that reason the unit keeps the resolved decision in a small pending state and raises `redirect_o` only while the delay-slot instruction is being presented. Fetch redirects on that cycle.

The link write is signalled in the same cycle as the linking instruction itself, so the register file can commit it at once. A branch or jump sitting in a delay slot is not allowed. The unit raises `slot_err_o` for it and treats it as inert: it writes no link and arms no slot. Cycles with `valid_i` low are stalls and leave the pending state untouched.

Top module: `br_resolve_unit`

## Requirements
- R1: After reset, and until the first valid control instruction is followed by a valid instruction, `redirect_o` and `slot_err_o` are low. `link_we_o` is low whenever `valid_i` is low.
- R2: Opcode 000100 branches when rs equals rt and opcode 000101 branches when they differ. The target is PC+4 plus the sign-extended 16-bit offset in bits 15:0, shifted left by two.
- R3: Opcode 000110 branches when rs is at most zero and opcode 000111 branches when rs is above zero. rs is read as signed and the target is computed as in R2.
- R4: Under opcode 000001, the rt field (bits 20:16) selects the test. 00000 branches on rs below zero, 00001 on rs at or above zero, 10000 is below zero with link, and 10001 is at or above zero with link. Any other rt code is not a control instruction.
- R5: A linking instruction asserts `link_we_o` in its own cycle with `link_val_o` = PC+8. The two linking zero-compare branches write register 31 whether the branch is taken or not.
- R6: Opcode 000010 jumps and opcode 000011 jumps and links to register 31. The target is bits 31:28 of PC+4, then the 26-bit index in bits 25:0, then two zero bits.
- R7: Under opcode 000000, function 001000 jumps to rs. Function 001001 jumps to rs and links to the register named by rd (bits 15:11).
- R8: A taken decision raises `redirect_o`, carrying its `target_o`, in the next cycle with `valid_i` high after the control instruction. That cycle is the delay slot. Stall cycles in between do not consume the slot and do not change `target_o`. A not-taken decision gives no redirect.
- R9: A control instruction in a delay slot asserts `slot_err_o` in that cycle. It writes no link and arms no slot, so the valid instruction after it sees no redirect.
- R10: A non-control instruction writes no link, and the valid instruction after it sees no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| rs_val_i | input | XLEN | Value of source register rs |
| rt_val_i | input | XLEN | Value of source register rt |
| redirect_o | output | 1 | Fetch must go to `target_o` after this delay-slot instruction |
| target_o | output | XLEN | Resolved target of the pending control instruction |
| link_we_o | output | 1 | Write `link_val_o` to `link_idx_o` |
| link_idx_o | output | 5 | Link destination register |
| link_val_o | output | XLEN | Return address, PC+8 |
| slot_err_o | output | 1 | Control instruction found in a delay slot |

## Verification
A corrupted pending state shows at the ports in the very next valid cycle. If the slot is armed wrongly, `redirect_o` appears after a plain instruction or goes missing after a taken branch. A stale latched target reaches `target_o` on the delay-slot cycle. Because stalls must not disturb that state, the stimulus inserts random idle cycles between a branch and its slot. It also places control instructions in delay slots, checking that the slot flag clears and that no second redirect follows.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_REGIMM  = 6'b000001;
  localparam logic [5:0] OP_J       = 6'b000010;
  localparam logic [5:0] OP_JAL     = 6'b000011;
  localparam logic [5:0] OP_BEQ     = 6'b000100;
  localparam logic [5:0] OP_BNE     = 6'b000101;
  localparam logic [5:0] OP_BLEZ    = 6'b000110;
  localparam logic [5:0] OP_BGTZ    = 6'b000111;
  localparam logic [5:0] FN_JR      = 6'b001000;
  localparam logic [5:0] FN_JALR    = 6'b001001;

  typedef enum logic [3:0] {
    K_NONE, K_EQ, K_NE, K_LEZ, K_GTZ, K_LTZ, K_GEZ, K_JIDX, K_JREG
  } cti_kind_e;

  typedef struct packed {
    logic              is_cti;
    cti_kind_e         kind;
    logic              link;
    logic [REG_AW-1:0] link_idx;
  } cti_dec_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
#(
  parameter int LINK_REG = 31
) (
  input  logic [31:0] instr_i,
  output cti_dec_t    dec_o
);
  logic [5:0]        op, fn;
  logic [REG_AW-1:0] rt_f, rd_f;

  assign op   = instr_i[31:26];
  assign fn   = instr_i[5:0];
  assign rt_f = instr_i[20:16];
  assign rd_f = instr_i[15:11];

  always_comb begin
    dec_o          = '0;
    dec_o.kind     = K_NONE;
    dec_o.link_idx = REG_AW'(LINK_REG);
    unique case (op)
      OP_BEQ:  dec_o.kind = K_EQ;
      OP_BNE:  dec_o.kind = K_NE;
      OP_BLEZ: dec_o.kind = K_LEZ;
      OP_BGTZ: dec_o.kind = K_GTZ;
      OP_J:    dec_o.kind = K_JIDX;
      OP_JAL: begin
        dec_o.kind = K_JIDX;
        dec_o.link = 1'b1;
      end
      OP_REGIMM: begin
        // rt[4] selects link, rt[0] selects >=0; other rt codes are not branches
        if (rt_f[3:1] == 3'b000) begin
          dec_o.kind = rt_f[0] ? K_GEZ : K_LTZ;
          dec_o.link = rt_f[4];
        end
      end
      OP_SPECIAL: begin
        if (fn == FN_JR) dec_o.kind = K_JREG;
        else if (fn == FN_JALR) begin
          dec_o.kind     = K_JREG;
          dec_o.link     = 1'b1;
          dec_o.link_idx = rd_f;
        end
      end
      default: ;
    endcase
    dec_o.is_cti = (dec_o.kind != K_NONE);
  end
endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cti_kind_e        kind_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  output logic             taken_o
);
  logic neg, zero;

  assign neg  = rs_i[XLEN-1];
  assign zero = (rs_i == '0);

  always_comb begin
    unique case (kind_i)
      K_EQ:           taken_o = (rs_i == rt_i);
      K_NE:           taken_o = (rs_i != rt_i);
      K_LEZ:          taken_o = neg | zero;
      K_GTZ:          taken_o = ~neg & ~zero;
      K_LTZ:          taken_o = neg;
      K_GEZ:          taken_o = ~neg;
      K_JIDX, K_JREG: taken_o = 1'b1;
      default:        taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target
  import br_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cti_kind_e       kind_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_val_o
);
  localparam int OFF_W = 16;
  localparam int IDX_W = 26;

  logic [XLEN-1:0] pc4, br_off, br_tgt, j_tgt;

  assign pc4        = pc_i + XLEN'(4);
  assign link_val_o = pc_i + XLEN'(8);
  assign br_off     = {{(XLEN-OFF_W-2){instr_i[OFF_W-1]}}, instr_i[OFF_W-1:0], 2'b00};
  assign br_tgt     = pc4 + br_off;
  assign j_tgt      = {pc4[XLEN-1:IDX_W+2], instr_i[IDX_W-1:0], 2'b00};

  always_comb begin
    unique case (kind_i)
      K_JIDX:  target_o = j_tgt;
      K_JREG:  target_o = rs_i;
      default: target_o = br_tgt;
    endcase
  end
endmodule

// File: rtl/br_slot_tracker.sv
module br_slot_tracker #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            arm_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] target_i,
  output logic            in_slot_o,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_slot_o <= 1'b0;
      taken_o   <= 1'b0;
      target_o  <= '0;
    end else if (adv_i) begin
      in_slot_o <= arm_i;
      if (arm_i) begin
        taken_o  <= taken_i;
        target_o <= target_i;
      end
    end
  end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int LINK_REG = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic              link_we_o,
  output logic [REG_AW-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic              slot_err_o
);
  cti_dec_t        dec;
  logic            cond_taken, in_slot, pend_taken, bad_slot;
  logic [XLEN-1:0] new_tgt;

  br_decode #(.LINK_REG(LINK_REG)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  br_cond #(.XLEN(XLEN)) u_cond (
    .kind_i  (dec.kind),
    .rs_i    (rs_val_i),
    .rt_i    (rt_val_i),
    .taken_o (cond_taken)
  );

  br_target #(.XLEN(XLEN)) u_tgt (
    .kind_i     (dec.kind),
    .instr_i    (instr_i),
    .pc_i       (pc_i),
    .rs_i       (rs_val_i),
    .target_o   (new_tgt),
    .link_val_o (link_val_o)
  );

  assign bad_slot = valid_i & in_slot & dec.is_cti;

  br_slot_tracker #(.XLEN(XLEN)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (valid_i),
    .arm_i     (dec.is_cti & ~bad_slot),
    .taken_i   (cond_taken),
    .target_i  (new_tgt),
    .in_slot_o (in_slot),
    .taken_o   (pend_taken),
    .target_o  (target_o)
  );

  assign redirect_o = valid_i & in_slot & pend_taken;
  assign slot_err_o = bad_slot;
  assign link_we_o  = valid_i & dec.link & ~bad_slot;
  assign link_idx_o = dec.link_idx;
endmodule

// File: rtl/br_resolve_checker.sv
module br_resolve_checker #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] pc_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o,
  input logic            link_we_o,
  input logic [4:0]      link_idx_o,
  input logic [XLEN-1:0] link_val_o,
  input logic            slot_err_o
);
  AST_LINK_PC8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> link_val_o == pc_i + XLEN'(8)); // R5

  AST_LINK_R31: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_we_o && instr_i[31:26] != 6'b000000) |-> link_idx_o == 5'd31); // R6

  AST_IDLE_NO_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !link_we_o); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(target_o)); // R8

  AST_NO_DOUBLE_REDIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o); // R9

  AST_ERR_NO_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_err_o |-> !link_we_o); // R9
endmodule

bind br_resolve_unit br_resolve_checker #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .instr_i    (instr_i),
  .pc_i       (pc_i),
  .redirect_o (redirect_o),
  .target_o   (target_o),
  .link_we_o  (link_we_o),
  .link_idx_o (link_idx_o),
  .link_val_o (link_val_o),
  .slot_err_o (slot_err_o)
);

// File: tb/br_resolve_unit_bench.sv
module br_resolve_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int N_RAND = 3000;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] pc_i = '0, rs_val_i = '0, rt_val_i = '0;
  logic            redirect_o, link_we_o, slot_err_o;
  logic [XLEN-1:0] target_o, link_val_o;
  logic [4:0]      link_idx_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  bit              m_slot = 0, m_taken = 0;
  logic [XLEN-1:0] m_tgt = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  br_resolve_unit #(.XLEN(XLEN)) u_br_resolve_unit (.*);

  task automatic check(input string tag, input logic [XLEN-1:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_decode(input logic [31:0] ins, input logic [XLEN-1:0] pc, rs, rt,
                            output bit cti, tk, lk, output logic [4:0] idx,
                            output logic [XLEN-1:0] tgt);
    logic [XLEN-1:0] p4;
    p4 = pc + 4;
    cti = 0; tk = 0; lk = 0; idx = 5'd31;
    tgt = p4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    case (ins[31:26])
      6'b000100: begin cti = 1; tk = (rs == rt); end                  // R2
      6'b000101: begin cti = 1; tk = (rs != rt); end                  // R2
      6'b000110: begin cti = 1; tk = ($signed(rs) <= 0); end          // R3
      6'b000111: begin cti = 1; tk = ($signed(rs) > 0); end           // R3
      6'b000001: begin                                                // R4
        case (ins[20:16])
          5'b00000: begin cti = 1; tk = ($signed(rs) < 0); end
          5'b00001: begin cti = 1; tk = ($signed(rs) >= 0); end
          5'b10000: begin cti = 1; lk = 1; tk = ($signed(rs) < 0); end
          5'b10001: begin cti = 1; lk = 1; tk = ($signed(rs) >= 0); end
          default: ;
        endcase
      end
      6'b000010, 6'b000011: begin                                     // R6
        cti = 1; tk = 1; lk = ins[26];
        tgt = {p4[31:28], ins[25:0], 2'b00};
      end
      6'b000000: begin                                                // R7
        if (ins[5:0] == 6'b001000 || ins[5:0] == 6'b001001) begin
          cti = 1; tk = 1; tgt = rs;
          if (ins[0]) begin lk = 1; idx = ins[15:11]; end
        end
      end
      default: ;
    endcase
  endtask

  // drive at negedge, check mid-low phase, update model at posedge
  task automatic step(input bit v, input logic [31:0] ins, input logic [XLEN-1:0] pc, rs, rt);
    bit cti, tk, lk, err;
    logic [4:0] idx;
    logic [XLEN-1:0] tgt;
    @(negedge clk_i);
    valid_i = v; instr_i = ins; pc_i = pc; rs_val_i = rs; rt_val_i = rt;
    ref_decode(ins, pc, rs, rt, cti, tk, lk, idx, tgt);
    err = v && m_slot && cti;
    #2;
    check("R8 redirect", XLEN'(redirect_o), XLEN'(v && m_slot && m_taken));
    if (v && m_slot && m_taken) check("R8 target", target_o, m_tgt);
    check("R9 slot_err", XLEN'(slot_err_o), XLEN'(err));
    check("R5 link_we", XLEN'(link_we_o), XLEN'(v && lk && !err));
    if (v && lk && !err) begin
      check("R5 link_val", link_val_o, pc + 8);
      check("R7 link_idx", XLEN'(link_idx_o), XLEN'(idx));
    end
    @(posedge clk_i);
    if (v) begin
      m_slot = cti && !err;
      if (m_slot) begin m_taken = tk; m_tgt = tgt; end
    end
  endtask

  function automatic logic [XLEN-1:0] pick_val();
    case ($urandom_range(0, 4))
      0: return '0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return XLEN'($urandom_range(1, 8));
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] pick_instr();
    logic [31:0] r;
    r = $urandom;
    case ($urandom_range(0, 11))
      0: return {6'b000100, r[25:0]};
      1: return {6'b000101, r[25:0]};
      2: return {6'b000110, r[25:0]};
      3: return {6'b000111, r[25:0]};
      4: return {6'b000001, r[25:21], r[20], 3'b000, r[16], r[15:0]};
      5: return {6'b000001, r[25:21], 5'b00010, r[15:0]};              // R4 not a branch
      6: return {5'b00001, r[26:0]};
      7: return {6'b000000, r[25:6], 5'b00100, r[0]};
      8: return {6'b000000, r[25:6], 6'b100001};                       // R10 plain
      default: return {6'b001001, r[25:0]};                            // R10 plain
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk_i);
    #1;
    check("R1 reset redirect", XLEN'(redirect_o), '0);
    check("R1 reset slot_err", XLEN'(slot_err_o), '0);
    check("R1 reset link_we", XLEN'(link_we_o), '0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2 taken BEQ, negative offset, then slot
    step(1, {6'b000100, 5'd1, 5'd2, 16'hFFFE}, 32'h0000_1000, 32'd5, 32'd5);
    step(1, 32'h0, 32'h0000_1004, 0, 0);
    // R8 stall between branch and slot
    step(1, {6'b000111, 5'd1, 5'd0, 16'h0010}, 32'h0000_2000, 32'd1, 0);
    step(0, {6'b000000, 20'h0, 6'b100001}, 32'h0, 0, 0);
    step(0, {6'b000100, 26'h0}, 32'h0, 0, 0);
    step(1, 32'h0, 32'h0000_2004, 0, 0);
    // R5 BLTZAL not taken still links
    step(1, {6'b000001, 5'd3, 5'b10000, 16'h0004}, 32'h0000_3000, 32'd7, 0);
    step(1, 32'h0, 32'h0000_3004, 0, 0);
    // R9 jump in delay slot of taken JAL, then no redirect after it
    step(1, {6'b000011, 26'h0000_100}, 32'hA000_0000, 0, 0);
    step(1, {6'b000000, 5'd4, 5'd0, 5'd9, 5'd0, 6'b001001}, 32'hA000_0004, 32'h40, 0);
    step(1, 32'h0, 32'hA000_0008, 0, 0);
    // R7 JALR to rd=9
    step(1, {6'b000000, 5'd4, 5'd0, 5'd9, 5'd0, 6'b001001}, 32'h0000_5000, 32'h1234_5678, 0);
    step(1, 32'h0, 32'h0000_5004, 0, 0);

    for (int i = 0; i < N_RAND; i++) begin
      logic [XLEN-1:0] a;
      a = pick_val();
      step($urandom_range(0, 9) < 8, pick_instr(), {$urandom} & ~32'h3, a,
           ($urandom_range(0, 2) == 0) ? a : pick_val());
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule